// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a 40-bit physical address. It walks a two-level table held in memory. A requester offers one translation at a time on a valid/ready handshake, with the virtual address and a write flag. The walker then reads the first-level entry and, when that entry is usable, the second-level (leaf) entry. It uses a read port that carries one 32-bit word per request and allows only one read in flight. The result is a physical address, or a fault with a cause code. A faulting access is redirected to a configured safe page at the same byte offset.

The virtual address splits 10/10/12. Bits 31:22 index the first-level table and bits 21:12 index the second-level table. Each table is one 4 KiB-aligned page of 1024 words. A word in either table uses bit 0 as present, bit 1 as exception (unmapped) and bit 2 as write permission. Bits 31:12 of a word hold a page number. In a leaf, bits 11:4 also hold physical address bits 39:32. Unmapped words hold the value 2, which is the exception bit alone. The first-level table base and the safe page come in as page numbers. A translation enable input selects between walking the tables and passing the address straight through.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high when the walker is idle. It goes low in the cycle after a request is accepted and stays low until the response handshake (`rsp_valid` and `rsp_ready` both high) completes. It is high again in the following cycle.
- R2: The first read of a walk goes to byte address {root_page, VA[31:22], 2'b00}.
- R3: The second read goes to byte address {L1[31:12], VA[21:12], 2'b00}, where L1 is the first-level word returned.
- R4: A successful walk returns `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = {leaf[11:4], leaf[31:12], VA[11:0]}, after exactly two reads.
- R5: A first-level word with bit 0 clear or bit 1 set ends the walk after one read, with `rsp_fault`=1 and `rsp_cause`=1.
- R6: A leaf word with bit 0 clear or bit 1 set gives `rsp_fault`=1 and `rsp_cause`=2.
- R7: A write request whose leaf is usable but has bit 2 clear gives `rsp_fault`=1 and `rsp_cause`=3. A read request through the same leaf succeeds.
- R8: On any fault, `rsp_paddr` = {safe_page, VA[11:0]}, `rsp_fault_va` equals the request address, and `rsp_cause` is nonzero exactly when `rsp_fault` is 1.
- R9: A request accepted while `xlate_en` is 0 issues no read and answers in the next cycle with `rsp_paddr` = {8'h00, VA} and `rsp_fault`=0.
- R10: At most one read is outstanding. `mem_rd_valid` and `mem_rd_addr` stay unchanged until `mem_rd_ready` is seen, and no read is issued while a response is pending.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr`, `rsp_fault`, `rsp_cause` and `rsp_fault_va` stay unchanged.
- R12: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xlate_en | input | 1 | 1 = walk tables, 0 = pass address through |
| root_page | input | 20 | Page number of the first-level table |
| safe_page | input | 28 | Page number that faulting accesses are redirected to |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table word |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 40 | Physical address, or safe address on a fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 first level absent, 2 leaf absent, 3 write protect |
| rsp_fault_va | output | 32 | Virtual address of the request |

## Verification
Translations are run through a populated region with a writeable leaf, a read-only leaf, and the top corner address 0xFFFFFFFF, where both indices and the offset are at their maximum. These cases separate the field placement in both read addresses and in the 40-bit result. First-level words that are absent, and words that are present but also carry the exception bit, are compared with their second-level counterparts. These show that the two levels raise distinct causes and that the walk stops after the first read. A write and a read through the same read-only leaf isolate the permission check. Pass-through mode, a memory that stalls read acceptance, and a requester that delays taking the result test the handshakes separately from the translation.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
    parameter int VA_W      = 32;
    parameter int PA_W      = 40;
    parameter int PAGE_BITS = 12;
    parameter int IDX_W     = 10;
    parameter int ENTRY_W   = 32;

    localparam int PAGE_NUM_W = VA_W - PAGE_BITS;
    localparam int PA_PAGE_W  = PA_W - PAGE_BITS;
    localparam int HI_W       = PA_W - VA_W;
    localparam int L1_LSB     = PAGE_BITS + IDX_W;
    localparam int BIT_PRES   = 0;
    localparam int BIT_EXC    = 1;
    localparam int BIT_WR     = 2;
    localparam int HI_LSB     = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_RESP
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'd0,
        CAUSE_L1_ABSENT  = 2'd1,
        CAUSE_L2_ABSENT  = 2'd2,
        CAUSE_WRITE_PROT = 2'd3
    } fault_cause_e;

    typedef struct packed {
        walk_state_e             st;
        logic [VA_W-1:0]         va;
        logic                    wr;
        logic [PAGE_NUM_W-1:0]   l2_page;
        logic [PA_W-1:0]         pa;
        logic                    fault;
        fault_cause_e            cause;
    } walk_regs_t;
endpackage

// File: rtl/pt_entry_dec.sv
module pt_entry_dec
    import pt_walk_pkg::*;
(
    input  logic [ENTRY_W-1:0]    entry,
    output logic                  usable,
    output logic                  writable,
    output logic [PAGE_NUM_W-1:0] page,
    output logic [HI_W-1:0]       pa_hi
);
    logic unused_entry_bit;

    // usable only when present and not flagged as an exception
    assign usable           = entry[BIT_PRES] & ~entry[BIT_EXC];
    assign writable         = entry[BIT_WR];
    assign page             = entry[ENTRY_W-1:PAGE_BITS];
    assign pa_hi            = entry[HI_LSB +: HI_W];
    assign unused_entry_bit = entry[3];
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int BASE_W = 20,
    parameter int IDX_W  = 10,
    parameter int ADDR_W = 32
) (
    input  logic [BASE_W-1:0] base_page,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] addr
);
    localparam int ALIGN_W = ADDR_W - BASE_W - IDX_W;

    // tables are page aligned and index*4 stays within one page
    assign addr = {base_page, index, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xlate_en,
    input  logic [PAGE_NUM_W-1:0] root_page,
    input  logic [PA_PAGE_W-1:0]  safe_page,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    output logic                  mem_rd_valid,
    input  logic                  mem_rd_ready,
    output logic [VA_W-1:0]       mem_rd_addr,
    input  logic                  mem_rsp_valid,
    input  logic [ENTRY_W-1:0]    mem_rsp_data,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_fault,
    output logic [1:0]            rsp_cause,
    output logic [VA_W-1:0]       rsp_fault_va
);
    walk_regs_t q, d;

    logic [VA_W-1:0]       l1_addr, l2_addr;
    logic                  ent_usable, ent_writable;
    logic [PAGE_NUM_W-1:0] ent_page;
    logic [HI_W-1:0]       ent_hi;

    pt_addr_gen #(.BASE_W(PAGE_NUM_W), .IDX_W(IDX_W), .ADDR_W(VA_W)) i_l1_addr (
        .base_page (root_page),
        .index     (q.va[VA_W-1:L1_LSB]),
        .addr      (l1_addr)
    );

    pt_addr_gen #(.BASE_W(PAGE_NUM_W), .IDX_W(IDX_W), .ADDR_W(VA_W)) i_l2_addr (
        .base_page (q.l2_page),
        .index     (q.va[L1_LSB-1:PAGE_BITS]),
        .addr      (l2_addr)
    );

    pt_entry_dec i_dec (
        .entry    (mem_rsp_data),
        .usable   (ent_usable),
        .writable (ent_writable),
        .page     (ent_page),
        .pa_hi    (ent_hi)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va    = req_vaddr;
                    d.wr    = req_write;
                    d.fault = 1'b0;
                    d.cause = CAUSE_NONE;
                    if (xlate_en) begin
                        d.st = ST_L1_REQ;
                    end else begin
                        d.pa = {{HI_W{1'b0}}, req_vaddr};
                        d.st = ST_RESP;
                    end
                end
            end
            ST_L1_REQ: if (mem_rd_ready) d.st = ST_L1_WAIT;
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ent_usable) begin
                        d.l2_page = ent_page;
                        d.st      = ST_L2_REQ;
                    end else begin
                        d.fault = 1'b1;
                        d.cause = CAUSE_L1_ABSENT;
                        d.pa    = {safe_page, q.va[PAGE_BITS-1:0]};
                        d.st    = ST_RESP;
                    end
                end
            end
            ST_L2_REQ: if (mem_rd_ready) d.st = ST_L2_WAIT;
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    d.st = ST_RESP;
                    if (!ent_usable) begin
                        d.fault = 1'b1;
                        d.cause = CAUSE_L2_ABSENT;
                        d.pa    = {safe_page, q.va[PAGE_BITS-1:0]};
                    end else if (q.wr && !ent_writable) begin
                        d.fault = 1'b1;
                        d.cause = CAUSE_WRITE_PROT;
                        d.pa    = {safe_page, q.va[PAGE_BITS-1:0]};
                    end else begin
                        d.pa = {ent_hi, ent_page, q.va[PAGE_BITS-1:0]};
                    end
                end
            end
            ST_RESP: if (rsp_ready) d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cause: CAUSE_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready    = (q.st == ST_IDLE);
    assign mem_rd_valid = (q.st == ST_L1_REQ) || (q.st == ST_L2_REQ);
    assign mem_rd_addr  = (q.st == ST_L2_REQ) ? l2_addr : l1_addr;
    assign rsp_valid    = (q.st == ST_RESP);
    assign rsp_paddr    = q.pa;
    assign rsp_fault    = q.fault;
    assign rsp_cause    = q.cause;
    assign rsp_fault_va = q.va;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walk_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            xlate_en,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            mem_rd_valid,
    input logic            mem_rd_ready,
    input logic [VA_W-1:0] mem_rd_addr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic [1:0]      rsp_cause
);
    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_no_accept_in_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_cause_matches_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

    p_bypass_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !xlate_en |=>
            rsp_valid && !rsp_fault && (rsp_paddr == {{(PA_W-VA_W){1'b0}}, $past(req_vaddr)}));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    p_no_rd_in_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_rd_valid);

    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=>
            rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_cause));
endmodule

bind pt_walker pt_walker_chk i_pt_walker_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xlate_en     (xlate_en),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .rsp_cause    (rsp_cause)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b1;
    logic [19:0] root_page = 20'h00100;
    logic [27:0] safe_page = 28'hABCDEF0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [39:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_fault_va;

    int checks = 0;
    int errors = 0;
    int stall_cycles = 0;
    int wait_cnt = 0;
    logic [31:0] tbl [int unsigned];
    logic [31:0] rd_q [$];

    // results of the last translation
    logic [39:0] got_pa;
    logic        got_fault;
    logic [1:0]  got_cause;
    logic [31:0] got_fva;
    int          got_reads;
    int          rd_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .root_page(root_page),
        .safe_page(safe_page), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_fault_va(rsp_fault_va)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lookup(input logic [31:0] a);
        return tbl.exists(a) ? tbl[a] : 32'h0000_0002;
    endfunction

    function automatic logic [31:0] l1_addr(input logic [31:0] va);
        return {root_page, va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] l2_addr(input logic [31:0] va);
        logic [31:0] e;
        e = lookup(l1_addr(va));
        return {e[31:12], va[21:12], 2'b00};
    endfunction

    function automatic logic [39:0] leaf_pa(input logic [31:0] va);
        logic [31:0] e;
        e = lookup(l2_addr(va));
        return {e[11:4], e[31:12], va[11:0]};
    endfunction

    // memory model: accepts reads after stall_cycles, returns data one cycle later
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic        prev_stalled = 1'b0;
    logic [31:0] prev_addr = '0;
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && prev_stalled) begin
                // R10: stalled read held with same address
                chk(mem_rd_valid && mem_rd_addr == prev_addr, "R10 read hold", {32'h0, mem_rd_addr}, {32'h0, prev_addr});
            end
            prev_stalled = rst_n && mem_rd_valid && !mem_rd_ready;
            prev_addr    = mem_rd_addr;
            if (rst_n && mem_rd_valid && mem_rd_ready) begin
                rd_q.push_back(mem_rd_addr);
                pend      = 1'b1;
                pend_addr = mem_rd_addr;
                wait_cnt  = 0;
            end else if (mem_rd_valid) begin
                wait_cnt++;
            end
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = lookup(pend_addr);
                pend          = 1'b0;
            end
            mem_rd_ready = mem_rd_valid && (wait_cnt >= stall_cycles);
        end
    end

    task automatic xlate(input logic [31:0] va, input logic wr, input logic en, input int hold);
        int cnt;
        @(negedge clk);
        xlate_en  = en;
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        rd_base   = rd_q.size();
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R1 busy after accept", {63'h0, req_ready}, 64'h0);
        cnt = 0;
        while (!rsp_valid && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        got_pa = rsp_paddr; got_fault = rsp_fault; got_cause = rsp_cause; got_fva = rsp_fault_va;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == got_pa && rsp_fault == got_fault &&
                rsp_cause == got_cause && rsp_fault_va == got_fva,
                "R11 response hold", {24'h0, rsp_paddr}, {24'h0, got_pa});
            chk(!req_ready, "R1 no accept while pending", {63'h0, req_ready}, 64'h0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready && !rsp_valid, "R1 ready after handshake", {62'h0, req_ready, rsp_valid}, 64'h2);
        got_reads = rd_q.size() - rd_base;
    endtask

    task automatic expect_ok(input logic [31:0] va, input logic wr, input string tag);
        xlate(va, wr, 1'b1, 0);
        chk(got_reads == 2, {tag, " R4 read count"}, got_reads, 2);
        if (got_reads == 2) begin
            chk(rd_q[rd_base] == l1_addr(va), {tag, " R2 first read"}, rd_q[rd_base], l1_addr(va));
            chk(rd_q[rd_base+1] == l2_addr(va), {tag, " R3 second read"}, rd_q[rd_base+1], l2_addr(va));
        end
        chk(!got_fault && got_cause == 0, {tag, " R4 no fault"}, {62'h0, got_cause}, 64'h0);
        chk(got_pa == leaf_pa(va), {tag, " R4 paddr"}, {24'h0, got_pa}, {24'h0, leaf_pa(va)});
    endtask

    task automatic expect_fault(input logic [31:0] va, input logic wr, input logic [1:0] cause,
                                input int reads, input string tag);
        xlate(va, wr, 1'b1, 0);
        chk(got_fault && got_cause == cause, {tag, " cause"}, {62'h0, got_cause}, {62'h0, cause});
        chk(got_reads == reads, {tag, " read count"}, got_reads, reads);
        chk(got_pa == {safe_page, va[11:0]}, {tag, " R8 safe paddr"}, {24'h0, got_pa}, {24'h0, safe_page, va[11:0]});
        chk(got_fva == va, {tag, " R8 fault va"}, {32'h0, got_fva}, {32'h0, va});
    endtask

    task automatic t_reset();
        chk(req_ready && !rsp_valid && !mem_rd_valid, "R12 reset state",
            {61'h0, req_ready, rsp_valid, mem_rd_valid}, 64'h4);
    endtask

    task automatic t_mapped();
        expect_ok(32'h1234_5678, 1'b0, "map read");
        expect_ok(32'h1234_5678, 1'b1, "map write");
        expect_ok(32'hFFFF_FFFF, 1'b0, "top corner");
    endtask

    task automatic t_write_protect();
        expect_fault(32'h1234_9ABC, 1'b1, 2'd3, 2, "R7 write protect");
        expect_ok(32'h1234_9ABC, 1'b0, "R7 read of read-only leaf");
    endtask

    task automatic t_l1_faults();
        expect_fault(32'h8000_1234, 1'b0, 2'd1, 1, "R5 l1 absent");
        expect_fault(32'h4000_0010, 1'b0, 2'd1, 1, "R5 l1 exception");
    endtask

    task automatic t_l2_faults();
        expect_fault(32'h1235_0ABC, 1'b0, 2'd2, 2, "R6 l2 absent");
        expect_fault(32'h1236_1FFF, 1'b1, 2'd2, 2, "R6 l2 exception");
    endtask

    task automatic t_bypass();
        xlate(32'hDEAD_BEEF, 1'b1, 1'b0, 0);
        chk(got_reads == 0, "R9 no reads", got_reads, 0);
        chk(!got_fault && got_pa == 40'h00_DEAD_BEEF, "R9 passthrough", {24'h0, got_pa}, 64'hDEAD_BEEF);
    endtask

    task automatic t_stall();
        stall_cycles = 3;
        expect_ok(32'h1234_5678, 1'b0, "R10 stalled memory");
        stall_cycles = 0;
    endtask

    task automatic t_hold();
        xlate(32'h1234_5678, 1'b0, 1'b1, 3);
        chk(got_pa == leaf_pa(32'h1234_5678), "R11 held paddr", {24'h0, got_pa}, {24'h0, leaf_pa(32'h1234_5678)});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tbl[32'h0010_0120] = 32'h0020_0001;
        tbl[32'h0020_0D14] = 32'h8765_45A5;
        tbl[32'h0020_0D24] = 32'hCAFE_0F01;
        tbl[32'h0010_0FFC] = 32'h0030_0001;
        tbl[32'h0030_0FFC] = 32'hFFFF_FFF5;
        tbl[32'h0010_0400] = 32'h0040_0003;
        tbl[32'h0020_0D84] = 32'h1111_1003;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mapped();
        t_write_protect();
        t_l1_faults();
        t_l2_faults();
        t_bypass();
        t_stall();
        t_hold();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule